// File: doc/BRIEF.md
# Maskable Content-Addressable Match Table

This block is a table of 256 stored 48-bit words. A search presents a key, and the key is compared against every stored word at the same time. A per-bit mask removes chosen bit positions from the compare. A mode input narrows the compare to the low 16 bits of each word. The per-entry match lines pass through a priority encoder, which gives a single registered hit flag and the index of the lowest matching entry.

Entries are loaded one at a time through a write port. The write port also carries the entry's valid bit, so an entry can be retired by writing it with the valid bit clear. Several tables can be chained into one larger prioritised table. A chain input tells a table that an upstream table has already matched. While that input is high, the table hides its own hit, and it passes the combined result on through its chain output.

Top module: `mask_cam`

## Requirements
- R1: After reset no entry is valid. `hit` is 0, `match_addr` is 0, and `casc_out` equals `casc_in` until the first search.
- R2: A write with `wr_en`=1 stores `wr_data` and `wr_valid` into entry `wr_addr`. Searches issued in later cycles see the new contents. A search issued in the same cycle as the write sees the old contents of that entry.
- R3: An entry whose valid bit is 0 never matches, whatever its stored data.
- R4: A mask bit of 1 at position b removes bit b from the compare, so that bit can never cause a mismatch. A mask bit of 0 makes bit b take part in the compare.
- R5: With `short_mode`=1 only bits [15:0] take part in the compare, and bits [47:16] act as masked. With `short_mode`=0 all 48 bits take part.
- R6: When several valid entries match, `match_addr` reports the lowest matching index, including index 255 at the top of the table.
- R7: Results are registered. `hit` and `match_addr` reflect the search strobed at the previous rising edge, and they hold their values in cycles with `srch_en`=0.
- R8: `match_addr` is 0 whenever `hit` is 0.
- R9: While `casc_in`=1, `hit` is 0 and `match_addr` is 0 in that same cycle. `casc_out` is always `casc_in` OR the table's registered local hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Entry index to write |
| wr_data | input | 48 | Word to store |
| wr_valid | input | 1 | Valid bit stored with the word |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 48 | Search key |
| srch_mask | input | 48 | Per-bit don't-care mask, 1 = bit excluded |
| short_mode | input | 1 | 1 = compare bits [15:0] only, 0 = all 48 bits |
| casc_in | input | 1 | An upstream table in the chain has already hit |
| hit | output | 1 | Registered hit, suppressed while casc_in is high |
| match_addr | output | 8 | Lowest matching index, 0 when hit is low |
| casc_out | output | 1 | casc_in OR the registered local hit |

## Verification
The assertions assume that `wr_en` and `srch_en` stay low while the internal reset is held. Under that assumption the write-landing and result-hold checks never compare against values captured during reset. The bench drives both strobes low throughout reset and for several cycles after release. All stimulus changes just after the falling edge, so each rising edge samples stable inputs. The random phase confines writes and keys to a small set of addresses and values, so that multiple matches, overwrites, invalidations and same-cycle write/search collisions occur often.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int CAM_DEPTH_DEF  = 256;
  localparam int CAM_WORD_W_DEF = 48;
  localparam int CAM_SHORT_W_DEF = 16;

  typedef enum logic {
    CMP_FULL  = 1'b0,
    CMP_SHORT = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 48,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          wr_valid,
  output logic [DEPTH-1:0][WORD_W-1:0]  words_o,
  output logic [DEPTH-1:0]              vld_o
);
  logic [DEPTH-1:0]             ent_we;
  logic [DEPTH-1:0][WORD_W-1:0] data_q;
  logic [DEPTH-1:0]             vld_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_comb ent_we[e] = wr_en && (wr_addr == ADDR_W'(e));

    // word storage: no reset, guarded by the valid bit
    always_ff @(posedge clk) begin
      if (ent_we[e]) begin
        data_q[e] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
      end else if (ent_we[e]) begin
        vld_q[e] <= wr_valid;
      end
    end
  end

  assign words_o = data_q;
  assign vld_o   = vld_q;

  // R2: a write lands in the addressed entry's valid bit
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (vld_q[$past(wr_addr)] == $past(wr_valid)));
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array
  import cam_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int WORD_W  = 48,
  parameter int SHORT_W = 16
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] words_i,
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [WORD_W-1:0]            key_i,
  input  logic [WORD_W-1:0]            mask_i,
  input  cmp_mode_e                    mode_i,
  output logic [DEPTH-1:0]             match_o
);
  localparam logic [WORD_W-1:0] SHORT_CARE =
    {{(WORD_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [WORD_W-1:0] width_care;
  logic [WORD_W-1:0] care;

  always_comb begin
    width_care = (mode_i == CMP_SHORT) ? SHORT_CARE : {WORD_W{1'b1}};
    care       = width_care & ~mask_i;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    always_comb begin
      diff       = (words_i[e] ^ key_i) & care;
      match_o[e] = vld_i[e] && (diff == '0);
    end
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mask_cam.sv
module mask_cam
  import cam_pkg::*;
#(
  parameter int DEPTH   = CAM_DEPTH_DEF,
  parameter int WORD_W  = CAM_WORD_W_DEF,
  parameter int SHORT_W = CAM_SHORT_W_DEF,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic              srch_en,
  input  logic [WORD_W-1:0] srch_key,
  input  logic [WORD_W-1:0] srch_mask,
  input  logic              short_mode,
  input  logic              casc_in,
  output logic              hit,
  output logic [ADDR_W-1:0] match_addr,
  output logic              casc_out
);
  localparam logic [DEPTH-1:0] ONE_V = DEPTH'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic [DEPTH-1:0][WORD_W-1:0] words;
  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0]             match_vec;
  logic                         enc_any;
  logic [ADDR_W-1:0]            enc_idx;
  cmp_mode_e                    mode;

  assign mode = cmp_mode_e'(short_mode);

  cam_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk      (clk),
    .rst_ni   (rst_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .words_o  (words),
    .vld_o    (vld)
  );

  cam_match_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_match (
    .words_i (words),
    .vld_i   (vld),
    .key_i   (srch_key),
    .mask_i  (srch_mask),
    .mode_i  (mode),
    .match_o (match_vec)
  );

  cam_prio_enc #(.N(DEPTH)) u_enc (
    .vec_i (match_vec),
    .any_o (enc_any),
    .idx_o (enc_idx)
  );

  // local result register, enabled by the search strobe
  logic              loc_hit_d, loc_hit_q;
  logic [ADDR_W-1:0] loc_addr_d, loc_addr_q;

  always_comb begin
    loc_hit_d  = loc_hit_q;
    loc_addr_d = loc_addr_q;
    if (srch_en) begin
      loc_hit_d  = enc_any;
      loc_addr_d = enc_any ? enc_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      loc_hit_q  <= 1'b0;
      loc_addr_q <= '0;
    end else begin
      loc_hit_q  <= loc_hit_d;
      loc_addr_q <= loc_addr_d;
    end
  end

  // chain gating on the registered result
  always_comb begin
    hit        = loc_hit_q && !casc_in;
    match_addr = hit ? loc_addr_q : '0;
    casc_out   = casc_in || loc_hit_q;
  end

  // R6: the encoder picks a set match line with no lower one set
  a_r6_enc_picks_set: assert property (@(posedge clk) disable iff (!rst_i)
    enc_any |-> match_vec[enc_idx]);
  a_r6_enc_lowest: assert property (@(posedge clk) disable iff (!rst_i)
    enc_any |-> ((match_vec & ((ONE_V << enc_idx) - ONE_V)) == '0));

  // R3: with nothing valid a search cannot hit
  a_r3_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_i)
    (srch_en && (vld == '0)) |=> !loc_hit_q);

  // R7: the result holds when no search is strobed
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !srch_en |=> ($stable(loc_hit_q) && $stable(loc_addr_q)));

  // R8: a stored miss carries address zero
  a_r8_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_i)
    !loc_hit_q |-> (loc_addr_q == '0));

  // R9: a local match reaches the chain output one cycle later
  a_r9_chain_out: assert property (@(posedge clk) disable iff (!rst_i)
    (srch_en && enc_any) |=> casc_out);
endmodule

// File: tb/mask_cam_bench.sv
module mask_cam_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [47:0] wr_data;
  logic        wr_valid;
  logic        srch_en;
  logic [47:0] srch_key;
  logic [47:0] srch_mask;
  logic        short_mode;
  logic        casc_in;
  logic        hit;
  logic [7:0]  match_addr;
  logic        casc_out;

  mask_cam u_mask_cam (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .srch_en(srch_en),
    .srch_key(srch_key), .srch_mask(srch_mask), .short_mode(short_mode),
    .casc_in(casc_in), .hit(hit), .match_addr(match_addr), .casc_out(casc_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    done  = 0;

  // behavioural reference
  logic [47:0] ref_data [256];
  bit          ref_vld  [256];
  bit          m_hit;
  int          m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ref_vld[i] = 0;
      m_hit  = 0;
      m_addr = 0;
    end else begin
      if (srch_en) begin
        logic [47:0] care;
        bit found;
        care  = short_mode ? 48'h0000_0000_FFFF : {48{1'b1}};
        care  = care & ~srch_mask;
        found = 0;
        m_addr = 0;
        for (int i = 0; i < 256; i++) begin
          if (!found && ref_vld[i] && (((ref_data[i] ^ srch_key) & care) == 48'h0)) begin
            found  = 1;
            m_addr = i;
          end
        end
        m_hit = found;
      end
      if (wr_en) begin
        ref_data[wr_addr] = wr_data;
        ref_vld[wr_addr]  = wr_valid;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    bit eh;
    eh = m_hit && !casc_in;
    chk("model hit", int'(hit), int'(eh));
    chk("model match_addr", int'(match_addr), eh ? m_addr : 0);
    chk("model casc_out", int'(casc_out), int'(casc_in || m_hit));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic expect_out(int eh, int ea, int ec);
    chk("hit", int'(hit), eh);
    chk("match_addr", int'(match_addr), ea);
    chk("casc_out", int'(casc_out), ec);
  endtask

  task automatic do_wr(int a, logic [47:0] d, bit v);
    wr_en = 1; wr_addr = 8'(a); wr_data = d; wr_valid = v;
    tick();
    wr_en = 0;
  endtask

  task automatic do_srch(logic [47:0] k, logic [47:0] m, bit s);
    srch_en = 1; srch_key = k; srch_mask = m; short_mode = s;
    tick();
    srch_en = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  localparam logic [47:0] VA = 48'hA5A5_0102_0304;
  localparam logic [47:0] VB = 48'h0BAD_F00D_4321;
  localparam logic [47:0] VC = 48'h1111_2222_7E57;
  localparam logic [47:0] VD = 48'hFFFF_0000_FFFF;

  initial begin
    logic [47:0] pool [4];
    pool[0] = VA; pool[1] = VB; pool[2] = VC; pool[3] = VD;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_valid = 0;
    srch_en = 0; srch_key = 0; srch_mask = 0; short_mode = 0; casc_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1: reset state, chain passes through
    tag = "R1";
    tick();
    expect_out(0, 0, 0);
    casc_in = 1;
    tick();
    expect_out(0, 0, 1);
    casc_in = 0;
    do_srch(48'h0, {48{1'b1}}, 0);
    expect_out(0, 0, 0);

    // R6: lowest of two matches wins; top index reachable
    tag = "R6";
    do_wr(9, VA, 1);
    do_wr(5, VA, 1);
    do_wr(255, VD, 1);
    do_srch(VA, 48'h0, 0);
    expect_out(1, 5, 1);
    do_srch(VD, 48'h0, 0);
    expect_out(1, 255, 1);

    // R2: write and search in one cycle see old contents
    tag = "R2";
    wr_en = 1; wr_addr = 8'd2; wr_data = VB; wr_valid = 1;
    srch_en = 1; srch_key = VB; srch_mask = 48'h0; short_mode = 0;
    tick();
    wr_en = 0; srch_en = 0;
    expect_out(0, 0, 0);
    do_srch(VB, 48'h0, 0);
    expect_out(1, 2, 1);

    // R3: invalidated entry is skipped
    tag = "R3";
    do_wr(5, VA, 0);
    do_srch(VA, 48'h0, 0);
    expect_out(1, 9, 1);

    // R4: masked bits ignored, unmasked bits compared
    tag = "R4";
    do_srch(VA ^ 48'h0000_0000_00F0, 48'h0000_0000_00F0, 0);
    expect_out(1, 9, 1);
    do_srch(VA ^ 48'h0000_0000_00F0, 48'h0, 0);
    expect_out(0, 0, 0);

    // R5: short mode compares bits [15:0] only
    tag = "R5";
    do_wr(20, VC, 1);
    do_srch(48'h9999_8888_7E57, 48'h0, 1);
    expect_out(1, 20, 1);
    do_srch(48'h9999_8888_7E57, 48'h0, 0);
    expect_out(0, 0, 0);

    // R8: miss reports address zero
    tag = "R8";
    expect_out(0, 0, 0);

    // R7: result holds without a strobe
    tag = "R7";
    do_srch(VA, 48'h0, 0);
    expect_out(1, 9, 1);
    srch_key = VB;
    tick();
    tick();
    expect_out(1, 9, 1);

    // R9: upstream hit suppresses local hit, chain out stays high
    tag = "R9";
    casc_in = 1;
    tick();
    expect_out(0, 0, 1);
    casc_in = 0;
    tick();
    expect_out(1, 9, 1);

    // random mix checked against the model every cycle (R2 R3 R4 R5 R6 R9)
    tag = "random";
    for (int c = 0; c < 3000; c++) begin
      int a;
      a = int'($urandom % 14);
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = 8'((a < 8) ? a : 242 + a);
      wr_data  = pool[$urandom % 4] ^ ((($urandom % 2) == 0) ? 48'h0001_0000_0000 : 48'h0);
      wr_valid = ($urandom % 5) != 0;
      srch_en  = ($urandom % 2) == 0;
      srch_key = pool[$urandom % 4] ^ ((($urandom % 3) == 0) ? 48'h0001_0000_0008 : 48'h0);
      srch_mask = (($urandom % 4) == 0) ? {16'($urandom), 32'($urandom)} : 48'h0;
      short_mode = ($urandom % 2) == 0;
      casc_in  = ($urandom % 4) == 0;
      tick();
    end
    wr_en = 0; srch_en = 0; casc_in = 0;
    tick();

    done = 1;
    summary();
  end
endmodule